// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder

This block sits on the device side of a DRAM that has one row strobe and two column strobes, one for each byte lane. It samples the active-low control pins (row strobe, two lane column strobes, write enable, output enable) on a fast system clock. From the order in which their edges arrive, it works out what kind of memory cycle the controller is running. For every recognised cycle it reports a type code with a one-clock strobe. It also produces a registered output enable for each lane and a one-clock write strobe for each lane. The memory array and the data path can use these directly.

The two lane strobes are merged into one internal column strobe. The first lane strobe to fall makes it active, and it becomes inactive only when the last lane strobe has risen. Each lane strobe still gates only its own byte lane. Refresh cycles are told apart by edge order alone: row strobe falling with a column strobe already low, or row strobe rising and falling while the column strobe stays low after an access. These cycles take their row from a 10-bit internal counter. Plain row-strobe cycles take the row from the address pins.

All outputs are registered. Each output reflects the pin values sampled at the clock edge before it.

Top module: `dcas_cycle_decoder`

## Requirements
- R1: `cas_int` becomes 1 one clock after either lane strobe is sampled low. It stays 1 while at least one lane strobe is low, and returns to 0 only one clock after both are sampled high.
- R2: `lane_oe[0]` (data bits 7:0) may be 1 only while `cas_n[0]` is low, and `lane_oe[1]` (bits 15:8) only while `cas_n[1]` is low. A lane whose strobe is high is never driven or written.
- R3: After reset, and while `ras_n` and both `cas_n` bits are high, `lane_oe` and `lane_wstb` are 0. After reset, `cyc_code` is 0 (standby) and `cyc_stb` is 0, whatever `we_n` and `oe_n` do.
- R4: If `ras_n` falls while a lane strobe is low and the row was idle, the cycle is a strobe-before-row refresh. It gives `cyc_code` 7 with `cyc_stb`, and no lane is driven.
- R5: `row_sel` takes `addr` at every falling `ras_n` that is not a refresh. If `ras_n` rises with no column strobe having fallen since it fell, the cycle is a row-only refresh and gives `cyc_code` 6 with `cyc_stb`.
- R6: If `we_n` is low when the internal column strobe falls, the cycle is an early write. `cyc_code` is 3 when both lanes are low and 4 when only one lane is low. Each lane pulses `lane_wstb` for one clock when its own strobe falls, and `lane_oe` stays 0.
- R7: If `we_n` is high when the internal column strobe falls, the cycle is a read. `cyc_code` is 1 for both lanes and 2 for one lane. A lane drives while its strobe is low, `oe_n` is low and `we_n` is high. Drive therefore starts at the later of the strobe and `oe_n` falling.
- R8: If `we_n` falls during a read while the column strobe is active, the cycle is a read-modify-write. It gives `cyc_code` 5 with `cyc_stb`, pulses `lane_wstb` for each lane whose strobe is low, and turns off `lane_oe`.
- R9: If `ras_n` rises and falls again while the column strobe stays low after an access, the cycle is a hidden refresh. It gives `cyc_code` 8. Read data stays driven throughout.
- R10: The refresh-row counter is 10 bits wide, starts at 0, advances by one on every strobe-before-row or hidden refresh, and wraps from 1023 to 0.
- R11: On a strobe-before-row or hidden refresh, `row_sel` shows the counter value, and `addr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 2 | Lane column strobes, active low; bit 0 lower lane, bit 1 upper lane |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Row address pins |
| cas_int | output | 1 | Merged internal column strobe, active high |
| lane_oe | output | 2 | Per-lane read drive enable |
| lane_wstb | output | 2 | Per-lane one-clock write strobe |
| cyc_stb | output | 1 | One-clock pulse when a cycle is recognised |
| cyc_code | output | 4 | Type of the last recognised cycle |
| row_sel | output | 10 | Row selected at the last row-strobe fall |

## Verification
The bench stresses edge order: byte strobes falling and rising at different clocks, `oe_n` falling after the strobe, and `we_n` falling inside a read. A merge that followed only one strobe would drop `cas_int` while the other lane was still low. A design that sampled `we_n` at the wrong edge would report a read-modify-write as an early write, and would either drive the bus during a write or miss the lane write pulses. Refresh cases check two things. First, a refresh entered from an access keeps data on the bus, while a refresh entered from idle does not. Second, the counter supplies the row regardless of `addr` and wraps past 1023. A design that confused these cases would report the wrong type code, drive the bus, or select the pin address.

// File: rtl/dcas_pkg.sv
package dcas_pkg;

    typedef enum logic [3:0] {
        CYC_STANDBY = 4'd0,
        CYC_RD_WORD = 4'd1,
        CYC_RD_BYTE = 4'd2,
        CYC_WR_WORD = 4'd3,
        CYC_WR_BYTE = 4'd4,
        CYC_RMW     = 4'd5,
        CYC_REF_RAS = 4'd6,
        CYC_REF_CBR = 4'd7,
        CYC_REF_HID = 4'd8
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_HOLD = 3'd4,
        ST_REF  = 3'd5
    } st_e;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_act;
        logic cas_fall;
        logic we_low;
        logic we_fall;
    } ctl_ev_s;

    function automatic cyc_e access_class(input logic is_write, input logic all_lanes);
        if (is_write) return all_lanes ? CYC_WR_WORD : CYC_WR_BYTE;
        return all_lanes ? CYC_RD_WORD : CYC_RD_BYTE;
    endfunction

endpackage

// File: rtl/dcas_pin_sampler.sv
module dcas_pin_sampler
    import dcas_pkg::*;
#(
    parameter int unsigned LANE_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic [LANE_N-1:0] cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    output ctl_ev_s           ev,
    output logic [LANE_N-1:0] lane_low,
    output logic [LANE_N-1:0] lane_fall,
    output logic              oe_low,
    output logic              cas_int
);
    localparam logic [LANE_N-1:0] ALL_HIGH = {LANE_N{1'b1}};

    logic              ras_q;
    logic              we_q;
    logic [LANE_N-1:0] cas_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q   <= 1'b1;
            we_q    <= 1'b1;
            cas_q   <= ALL_HIGH;
            cas_int <= 1'b0;
        end else begin
            ras_q   <= ras_n;
            we_q    <= we_n;
            cas_q   <= cas_n;
            cas_int <= (cas_n != ALL_HIGH);
        end
    end

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane_edge
        assign lane_low[g]  = ~cas_n[g];
        assign lane_fall[g] = cas_q[g] & ~cas_n[g];
    end

    always_comb begin
        ev.ras_fall = ras_q & ~ras_n;
        ev.ras_rise = ~ras_q & ras_n;
        ev.cas_act  = (cas_n != ALL_HIGH);
        ev.cas_fall = (cas_q == ALL_HIGH) && (cas_n != ALL_HIGH);
        ev.we_low   = ~we_n;
        ev.we_fall  = we_q & ~we_n;
    end

    assign oe_low = ~oe_n;

    // R1: first falling lane strobe activates the merged strobe
    p_cas_first_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(lane_fall) != '0) |-> cas_int);

    // R1: merged strobe stays active while any lane strobe is still low
    p_cas_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(cas_int) && ($past(cas_n) != ALL_HIGH) |-> cas_int);

endmodule

// File: rtl/dcas_cycle_fsm.sv
module dcas_cycle_fsm
    import dcas_pkg::*;
#(
    parameter int unsigned LANE_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_ev_s           ev,
    input  logic [LANE_N-1:0] lane_low,
    output logic              acc_nxt,
    output logic              rd_nxt,
    output logic              go_ref,
    output logic              cyc_stb,
    output cyc_e              cyc_code
);
    st_e  st_q, st_n;
    logic rd_q;
    logic used_q, used_n;
    logic held_q, held_n;
    logic stb_n;
    cyc_e code_n;
    logic full;

    assign full = &lane_low;

    always_comb begin
        st_n   = st_q;
        rd_nxt = rd_q;
        used_n = used_q;
        held_n = held_q;
        stb_n  = 1'b0;
        code_n = cyc_code;
        go_ref = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ev.ras_fall) begin
                    if (ev.cas_act) begin
                        st_n   = ST_REF;
                        held_n = 1'b0;
                        stb_n  = 1'b1;
                        code_n = CYC_REF_CBR;
                        go_ref = 1'b1;
                    end else begin
                        st_n   = ST_ROW;
                        used_n = 1'b0;
                    end
                end
            end
            ST_ROW: begin
                if (ev.ras_rise) begin
                    st_n = ST_IDLE;
                    if (!used_q) begin
                        stb_n  = 1'b1;
                        code_n = CYC_REF_RAS;
                    end
                end else if (ev.cas_fall) begin
                    used_n = 1'b1;
                    stb_n  = 1'b1;
                    code_n = access_class(ev.we_low, full);
                    if (ev.we_low) begin
                        st_n   = ST_WR;
                        rd_nxt = 1'b0;
                    end else begin
                        st_n   = ST_RD;
                        rd_nxt = 1'b1;
                    end
                end
            end
            ST_RD, ST_WR: begin
                if (ev.ras_rise) begin
                    st_n   = ev.cas_act ? ST_HOLD : ST_IDLE;
                    held_n = ev.cas_act;
                end else if (!ev.cas_act) begin
                    st_n = ST_ROW;
                end else if (st_q == ST_RD && ev.we_fall) begin
                    stb_n  = 1'b1;
                    code_n = CYC_RMW;
                end
            end
            ST_HOLD: begin
                if (!ev.cas_act) begin
                    st_n = ST_IDLE;
                end else if (ev.ras_fall) begin
                    st_n   = ST_REF;
                    stb_n  = 1'b1;
                    code_n = held_q ? CYC_REF_HID : CYC_REF_CBR;
                    go_ref = 1'b1;
                end
            end
            ST_REF: begin
                if (ev.ras_rise) begin
                    st_n = ev.cas_act ? ST_HOLD : ST_IDLE;
                end else if (!ev.cas_act) begin
                    held_n = 1'b0;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (!ev.cas_act) rd_nxt = 1'b0;
    end

    assign acc_nxt = (st_n == ST_RD) || (st_n == ST_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            rd_q     <= 1'b0;
            used_q   <= 1'b0;
            held_q   <= 1'b0;
            cyc_stb  <= 1'b0;
            cyc_code <= CYC_STANDBY;
        end else begin
            st_q     <= st_n;
            rd_q     <= rd_nxt;
            used_q   <= used_n;
            held_q   <= held_n;
            cyc_stb  <= stb_n;
            cyc_code <= code_n;
        end
    end

    // R4: a counter step always comes with a refresh-type cycle report
    p_ref_report_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(go_ref) |->
            cyc_stb && (cyc_code == CYC_REF_CBR || cyc_code == CYC_REF_HID));

    // R5: a row-only refresh is reported only after the row strobe rose
    p_rasonly_edge_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && cyc_stb && cyc_code == CYC_REF_RAS |-> $past(ev.ras_rise));

endmodule

// File: rtl/dcas_lane_gate.sv
module dcas_lane_gate #(
    parameter int unsigned LANE_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_N-1:0] lane_low,
    input  logic [LANE_N-1:0] lane_fall,
    input  logic              oe_low,
    input  logic              we_low,
    input  logic              we_fall,
    input  logic              acc_nxt,
    input  logic              rd_nxt,
    output logic [LANE_N-1:0] lane_oe,
    output logic [LANE_N-1:0] lane_wstb
);
    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_oe[g]   <= 1'b0;
                lane_wstb[g] <= 1'b0;
            end else begin
                lane_oe[g]   <= rd_nxt & lane_low[g] & oe_low & ~we_low;
                lane_wstb[g] <= acc_nxt & lane_low[g] & we_low & (lane_fall[g] | we_fall);
            end
        end

        // R2: a lane is driven only if its own strobe was low
        p_lane_own_r2: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && lane_oe[g] |-> $past(lane_low[g]));

        // R2: a lane write pulse only follows its own low strobe
        p_lane_wown_r2: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && lane_wstb[g] |-> $past(lane_low[g]));
    end

    // R8: write pulses and read drive never overlap
    p_no_drive_on_write_r8: assert property (@(posedge clk) disable iff (rst)
        (lane_wstb != '0) |-> (lane_oe == '0));

endmodule

// File: rtl/dcas_refresh_row.sv
module dcas_refresh_row #(
    parameter int unsigned ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_fall,
    input  logic             go_ref,
    input  logic [ROW_W-1:0] addr,
    output logic [ROW_W-1:0] row_sel
);
    logic [ROW_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            row_sel <= '0;
        end else begin
            if (go_ref) cnt_q <= cnt_q + ROW_W'(1);
            if (ras_fall) row_sel <= go_ref ? cnt_q : addr;
        end
    end

    // R10: one step per refresh, wrapping at the counter width
    p_ctr_step_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(go_ref) |-> cnt_q == $past(cnt_q) + ROW_W'(1));

    // R11: internal refresh takes the counter, never the pins
    p_row_src_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(go_ref) |-> row_sel == $past(cnt_q));

endmodule

// File: rtl/dcas_cycle_decoder.sv
module dcas_cycle_decoder
    import dcas_pkg::*;
#(
    parameter int unsigned LANE_N = 2,
    parameter int unsigned ROW_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic [LANE_N-1:0] cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ROW_W-1:0]  addr,
    output logic              cas_int,
    output logic [LANE_N-1:0] lane_oe,
    output logic [LANE_N-1:0] lane_wstb,
    output logic              cyc_stb,
    output logic [3:0]        cyc_code,
    output logic [ROW_W-1:0]  row_sel
);
    ctl_ev_s           ev;
    logic [LANE_N-1:0] lane_low;
    logic [LANE_N-1:0] lane_fall;
    logic              oe_low;
    logic              acc_nxt;
    logic              rd_nxt;
    logic              go_ref;
    cyc_e              code_q;

    dcas_pin_sampler #(.LANE_N(LANE_N)) u_sampler (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .ev(ev), .lane_low(lane_low), .lane_fall(lane_fall), .oe_low(oe_low),
        .cas_int(cas_int)
    );

    dcas_cycle_fsm #(.LANE_N(LANE_N)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .lane_low(lane_low),
        .acc_nxt(acc_nxt), .rd_nxt(rd_nxt), .go_ref(go_ref),
        .cyc_stb(cyc_stb), .cyc_code(code_q)
    );

    dcas_lane_gate #(.LANE_N(LANE_N)) u_lanes (
        .clk(clk), .rst(rst), .lane_low(lane_low), .lane_fall(lane_fall),
        .oe_low(oe_low), .we_low(ev.we_low), .we_fall(ev.we_fall),
        .acc_nxt(acc_nxt), .rd_nxt(rd_nxt),
        .lane_oe(lane_oe), .lane_wstb(lane_wstb)
    );

    dcas_refresh_row #(.ROW_W(ROW_W)) u_refrow (
        .clk(clk), .rst(rst), .ras_fall(ev.ras_fall), .go_ref(go_ref),
        .addr(addr), .row_sel(row_sel)
    );

    assign cyc_code = code_q;

    // R3: idle pins leave the bus and the write strobes quiet
    p_standby_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(ras_n) && ($past(cas_n) == {LANE_N{1'b1}}) |->
            (lane_oe == '0) && (lane_wstb == '0));

    // R4: refresh from idle never drives data
    p_cbr_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        cyc_stb && cyc_code == CYC_REF_CBR |-> lane_oe == '0);

    // R6: early write keeps outputs off
    p_ewrite_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        cyc_stb && (cyc_code == CYC_WR_WORD || cyc_code == CYC_WR_BYTE) |-> lane_oe == '0);

    // R8: read-modify-write reports with a write pulse and no drive
    p_rmw_write_r8: assert property (@(posedge clk) disable iff (rst)
        cyc_stb && cyc_code == CYC_RMW |-> (lane_wstb != '0) && (lane_oe == '0));

endmodule

// File: tb/test_dcas_cycle_decoder.sv
`timescale 1ns/1ps
module test_dcas_cycle_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ras_n = 1'b1;
    logic [1:0] cas_n = 2'b11;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [9:0] addr = '0;
    logic       cas_int;
    logic [1:0] lane_oe;
    logic [1:0] lane_wstb;
    logic       cyc_stb;
    logic [3:0] cyc_code;
    logic [9:0] row_sel;

    int n_chk = 0;
    int n_err = 0;
    int exp_row = 0;

    always #4 clk = ~clk;

    dcas_cycle_decoder i_dcas_cycle_decoder (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .cas_int(cas_int), .lane_oe(lane_oe), .lane_wstb(lane_wstb),
        .cyc_stb(cyc_stb), .cyc_code(cyc_code), .row_sel(row_sel)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_pins();
        ras_n = 1'b1; cas_n = 2'b11; we_n = 1'b1; oe_n = 1'b1; tick();
    endtask

    task automatic t_reset();
        chk("R3", "reset oe", lane_oe, 0);
        chk("R3", "reset wstb", lane_wstb, 0);
        chk("R3", "reset code", cyc_code, 0);
        chk("R3", "reset stb", cyc_stb, 0);
        chk("R1", "reset cas_int", cas_int, 0);
        chk("R10", "reset row", row_sel, 0);
    endtask

    task automatic t_word_read();
        addr = 10'd5; ras_n = 1'b0; oe_n = 1'b0; tick();
        chk("R5", "row latch", row_sel, 5);
        cas_n = 2'b00; tick();
        chk("R7", "word read stb", cyc_stb, 1);
        chk("R7", "word read code", cyc_code, 1);
        chk("R7", "word read drive", lane_oe, 3);
        chk("R1", "cas_int on", cas_int, 1);
        tick();
        chk("R7", "stb one clock", cyc_stb, 0);
        cas_n = 2'b11; tick();
        chk("R2", "drive off on strobe high", lane_oe, 0);
        chk("R1", "cas_int off", cas_int, 0);
        ras_n = 1'b1; tick();
        chk("R5", "no row-only after access", cyc_stb, 0);
        idle_pins();
    endtask

    task automatic t_byte_read_late_oe();
        ras_n = 1'b0; tick();
        cas_n = 2'b10; tick();
        chk("R7", "byte read code", cyc_code, 2);
        chk("R7", "no drive before oe", lane_oe, 0);
        oe_n = 1'b0; tick();
        chk("R7", "oe launches lower", lane_oe, 1);
        cas_n = 2'b00; tick();
        chk("R2", "upper joins", lane_oe, 3);
        cas_n = 2'b01; tick();
        chk("R2", "lower released", lane_oe, 2);
        chk("R1", "cas_int held by upper", cas_int, 1);
        cas_n = 2'b11; tick();
        chk("R1", "cas_int after last rise", cas_int, 0);
        idle_pins();
    endtask

    task automatic t_early_write();
        we_n = 1'b0; oe_n = 1'b0; ras_n = 1'b0; tick();
        cas_n = 2'b00; tick();
        chk("R6", "word write code", cyc_code, 3);
        chk("R6", "word write pulse", lane_wstb, 3);
        chk("R6", "write no drive", lane_oe, 0);
        tick();
        chk("R6", "pulse one clock", lane_wstb, 0);
        idle_pins();
        we_n = 1'b0; ras_n = 1'b0; tick();
        cas_n = 2'b01; tick();
        chk("R6", "byte write code", cyc_code, 4);
        chk("R2", "upper only pulse", lane_wstb, 2);
        cas_n = 2'b00; tick();
        chk("R6", "late lower pulse", lane_wstb, 1);
        chk("R6", "late lane no new cycle", cyc_stb, 0);
        idle_pins();
    endtask

    task automatic t_rmw();
        oe_n = 1'b0; ras_n = 1'b0; tick();
        cas_n = 2'b00; tick();
        chk("R7", "read before modify", lane_oe, 3);
        we_n = 1'b0; tick();
        chk("R8", "rmw stb", cyc_stb, 1);
        chk("R8", "rmw code", cyc_code, 5);
        chk("R8", "rmw pulse", lane_wstb, 3);
        chk("R8", "rmw drive off", lane_oe, 0);
        idle_pins();
    endtask

    task automatic t_ras_only();
        addr = 10'h2A5; ras_n = 1'b0; tick();
        chk("R5", "row-only latch", row_sel, 10'h2A5);
        addr = 10'h011; tick();
        ras_n = 1'b1; tick();
        chk("R5", "row-only stb", cyc_stb, 1);
        chk("R5", "row-only code", cyc_code, 6);
        chk("R5", "row-only no drive", lane_oe, 0);
        idle_pins();
    endtask

    task automatic cbr(input logic checked);
        oe_n = 1'b0; cas_n = 2'b00; tick();
        if (checked) chk("R4", "no cycle before row fall", cyc_stb, 0);
        addr = 10'(exp_row ^ 10'h3FF); ras_n = 1'b0; tick();
        if (checked) begin
            chk("R4", "cbr stb", cyc_stb, 1);
            chk("R4", "cbr code", cyc_code, 7);
            chk("R4", "cbr no drive", lane_oe, 0);
            chk("R11", "cbr row from counter", row_sel, 32'(exp_row));
        end
        exp_row = (exp_row + 1) % 1024;
        ras_n = 1'b1; tick();
        cas_n = 2'b11; oe_n = 1'b1; tick();
    endtask

    task automatic t_hidden();
        addr = 10'd77; oe_n = 1'b0; ras_n = 1'b0; tick();
        cas_n = 2'b00; tick();
        chk("R7", "read before hidden", lane_oe, 3);
        ras_n = 1'b1; tick();
        chk("R9", "data held row high", lane_oe, 3);
        ras_n = 1'b0; tick();
        chk("R9", "hidden code", cyc_code, 8);
        chk("R9", "hidden stb", cyc_stb, 1);
        chk("R9", "hidden keeps data", lane_oe, 3);
        chk("R11", "hidden row from counter", row_sel, 32'(exp_row));
        exp_row = (exp_row + 1) % 1024;
        ras_n = 1'b1; tick();
        cas_n = 2'b11; tick();
        chk("R9", "release after strobe", lane_oe, 0);
        idle_pins();
    endtask

    task automatic t_standby();
        we_n = 1'b0; oe_n = 1'b0; tick();
        we_n = 1'b1; tick();
        chk("R3", "standby oe", lane_oe, 0);
        chk("R3", "standby wstb", lane_wstb, 0);
        chk("R3", "standby stb", cyc_stb, 0);
        idle_pins();
    endtask

    task automatic t_wrap();
        while (exp_row != 1023) cbr(1'b0);
        cbr(1'b1);
        chk("R10", "wrapped to zero", 32'(exp_row), 0);
        cbr(1'b1);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_word_read();
        t_byte_read_late_oe();
        t_early_write();
        t_rmw();
        t_ras_only();
        cbr(1'b1);
        cbr(1'b1);
        t_hidden();
        t_standby();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule